// File: doc/BRIEF.md
# Fault Input Conditioner and Output Gate

This block takes an external fault (break) line and turns it into a clean, qualified break signal. It then uses that signal to control a main output enable, and the main enable decides whether the complementary channel outputs carry their PWM values or sit at their idle levels. The raw line is first corrected for polarity. It then passes through a digital filter, whose sampling divisor and consecutive-sample count come from a 4-bit setting. Setting 0 bypasses the filter altogether.

A qualified break drops the main enable in the same cycle, with no wait for a clock edge, and holds it low for as long as the break lasts. Software sets or clears the main enable directly. When auto-enable is on, an update-event pulse can also set it. A sticky event flag records that a break happened, and a clear pulse removes the flag.

Top module: `brk_gate`

## Requirements
- R1: With filter setting 0, the qualified break output follows the polarity-corrected pin combinationally, with no sampling delay.
- R2: Settings 1, 2 and 3 sample on every kernel clock and change the qualified output after 2, 4 and 8 consecutive agreeing samples.
- R3: Settings 4 to 15 sample on every Dth dead-time clock enable. D is 2 for settings 4 and 5, 4 for settings 6 and 7, 8 for settings 8 and 9, 16 for settings 10 to 12, and 32 for settings 13 to 15. The required sample count is 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8 for settings 4 to 15 in that order.
- R4: A sample equal to the current qualified level restarts the count, so a pulse shorter than the required run never changes the output.
- R5: The polarity input selects the asserted pin level: 1 means the pin is active high, and 0 means it is active low.
- R6: While the break enable is 0, an asserted break changes neither the main enable nor the event flag.
- R7: An enabled, qualified break forces the main enable output low in the same cycle, before any clock edge, and clears its stored state at the next edge.
- R8: An update-event pulse sets the main enable only while auto-enable is 1. A software set pulse always sets it.
- R9: While an enabled break is active, a software set or an update event in the same cycle leaves the main enable at 0.
- R10: While the main enable is 0, both output vectors equal their idle-level inputs. While it is 1, each output bit carries its PWM bit if its channel enable is 1 and its idle bit otherwise.
- R11: The event flag is set on any cycle with an enabled, qualified break and stays set after the break ends. A clear pulse removes it, and a set in the same cycle takes priority over the clear.
- R12: A software clear pulse resets the main enable at the next edge, and it wins over a simultaneous software set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dts_ce | input | 1 | Dead-time clock enable, one pulse per dead-time tick |
| brk_pin | input | 1 | Raw break line |
| flt_sel | input | 4 | Filter setting |
| brk_pol | input | 1 | Asserted pin level |
| brk_en | input | 1 | Break enable |
| auto_en | input | 1 | Allow update event to set the main enable |
| sw_set | input | 1 | Software set pulse for the main enable |
| sw_clr | input | 1 | Software clear pulse for the main enable |
| upd_evt | input | 1 | Update event pulse |
| flag_clr | input | 1 | Clear pulse for the event flag |
| en_p | input | N_CH | True-output channel enables |
| en_n | input | N_CH | Complementary-output channel enables |
| pwm_p | input | N_CH | True PWM values |
| pwm_n | input | N_CH | Complementary PWM values |
| idle_p | input | N_CH | True-output idle levels |
| idle_n | input | N_CH | Complementary-output idle levels |
| brk_filt | output | 1 | Qualified break level (1 = asserted) |
| brk_flag | output | 1 | Sticky break event flag |
| moe | output | 1 | Main output enable |
| out_p | output | N_CH | Gated true outputs |
| out_n | output | N_CH | Gated complementary outputs |

## Verification
The hardest case to reach is the slow divided settings. The moment the qualified level changes depends on the prescaler phase, and that phase cannot be seen at the ports. The stimulus therefore checks each such setting at two points: one just before the earliest possible change, and one at the latest possible change. This proves both the divisor and the count without relying on the phase. A second difficult case is a break that coincides with a software set and an update event. The stimulus drives all three in the same cycle and then confirms that the main enable stays low while the break is active.

// File: rtl/brk_gate.sv
module brk_gate #(
  parameter int N_CH  = 2,
  parameter int DIV_W = 6,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dts_ce,
  input  logic            brk_pin,
  input  logic [3:0]      flt_sel,
  input  logic            brk_pol,
  input  logic            brk_en,
  input  logic            auto_en,
  input  logic            sw_set,
  input  logic            sw_clr,
  input  logic            upd_evt,
  input  logic            flag_clr,
  input  logic [N_CH-1:0] en_p,
  input  logic [N_CH-1:0] en_n,
  input  logic [N_CH-1:0] pwm_p,
  input  logic [N_CH-1:0] pwm_n,
  input  logic [N_CH-1:0] idle_p,
  input  logic [N_CH-1:0] idle_n,
  output logic            brk_filt,
  output logic            brk_flag,
  output logic            moe,
  output logic [N_CH-1:0] out_p,
  output logic [N_CH-1:0] out_n
);

  function automatic logic [DIV_W-1:0] div_of(input logic [3:0] s);
    case (s)
      4'd4, 4'd5:         div_of = DIV_W'(2);
      4'd6, 4'd7:         div_of = DIV_W'(4);
      4'd8, 4'd9:         div_of = DIV_W'(8);
      4'd10, 4'd11, 4'd12: div_of = DIV_W'(16);
      4'd13, 4'd14, 4'd15: div_of = DIV_W'(32);
      default:            div_of = DIV_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] need_of(input logic [3:0] s);
    case (s)
      4'd1:                       need_of = CNT_W'(2);
      4'd2:                       need_of = CNT_W'(4);
      4'd10, 4'd13:               need_of = CNT_W'(5);
      4'd4, 4'd6, 4'd8, 4'd11, 4'd14: need_of = CNT_W'(6);
      4'd3, 4'd5, 4'd7, 4'd9, 4'd12, 4'd15: need_of = CNT_W'(8);
      default:                    need_of = CNT_W'(1);
    endcase
  endfunction

  logic [DIV_W-1:0] pcnt, div_m1;
  logic [CNT_W-1:0] run, need;
  logic             lvl, filt_q, moe_q, slow, tick, brk_act;

  assign lvl    = brk_pin ~^ brk_pol;
  assign slow   = flt_sel > 4'd3;
  assign div_m1 = div_of(flt_sel) - DIV_W'(1);
  assign need   = need_of(flt_sel);
  assign tick   = slow ? (dts_ce && pcnt >= div_m1) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (!slow)
      pcnt <= '0;
    else if (dts_ce)
      pcnt <= (pcnt >= div_m1) ? '0 : pcnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run    <= '0;
    end else if (flt_sel == 4'd0) begin
      filt_q <= lvl;
      run    <= '0;
    end else if (tick) begin
      if (lvl == filt_q)
        run <= '0;
      else if (run + CNT_W'(1) >= need) begin
        filt_q <= lvl;
        run    <= '0;
      end else
        run <= run + CNT_W'(1);
    end
  end

  assign brk_filt = (flt_sel == 4'd0) ? lvl : filt_q;
  assign brk_act  = brk_en & brk_filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      moe_q <= 1'b0;
    else if (brk_act || sw_clr)
      moe_q <= 1'b0;
    else if (sw_set || (auto_en && upd_evt))
      moe_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      brk_flag <= 1'b0;
    else if (brk_act)
      brk_flag <= 1'b1;
    else if (flag_clr)
      brk_flag <= 1'b0;
  end

  assign moe   = moe_q & ~brk_act;
  assign out_p = moe ? ((en_p & pwm_p) | (~en_p & idle_p)) : idle_p;
  assign out_n = moe ? ((en_n & pwm_n) | (~en_n & idle_n)) : idle_n;

endmodule

// File: rtl/brk_gate_chk.sv
module brk_gate_chk #(
  parameter int N_CH = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            brk_pin,
  input logic [3:0]      flt_sel,
  input logic            brk_pol,
  input logic            brk_en,
  input logic            auto_en,
  input logic            sw_set,
  input logic            sw_clr,
  input logic            upd_evt,
  input logic            flag_clr,
  input logic [N_CH-1:0] idle_p,
  input logic [N_CH-1:0] idle_n,
  input logic            brk_filt,
  input logic            brk_flag,
  input logic            moe,
  input logic [N_CH-1:0] out_p,
  input logic [N_CH-1:0] out_n
);

  assert_bypass_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_en && flt_sel == 4'd0 && brk_pin == brk_pol) |-> !moe);

  assert_break_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_en && brk_filt) |=> !moe);

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_en && brk_filt) |=> brk_flag);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(brk_en && brk_filt)) |=> !brk_flag);

  assert_idle_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !moe |-> (out_p == idle_p && out_n == idle_n));

  assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe && !sw_set && !(auto_en && upd_evt)) |=> !moe);

  assert_sw_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !moe);

endmodule

bind brk_gate brk_gate_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_pin(brk_pin), .flt_sel(flt_sel),
  .brk_pol(brk_pol), .brk_en(brk_en), .auto_en(auto_en), .sw_set(sw_set),
  .sw_clr(sw_clr), .upd_evt(upd_evt), .flag_clr(flag_clr),
  .idle_p(idle_p), .idle_n(idle_n), .brk_filt(brk_filt),
  .brk_flag(brk_flag), .moe(moe), .out_p(out_p), .out_n(out_n)
);

// File: tb/test_brk_gate.sv
`timescale 1ns/1ps
module test_brk_gate;
  localparam int N_CH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dts_ce = 1'b1, brk_pin = 1'b0, brk_pol = 1'b1, brk_en = 1'b0;
  logic auto_en = 1'b0, sw_set = 1'b0, sw_clr = 1'b0, upd_evt = 1'b0, flag_clr = 1'b0;
  logic [3:0] flt_sel = 4'd0;
  logic [N_CH-1:0] en_p = 2'b11, en_n = 2'b01, pwm_p = 2'b10, pwm_n = 2'b01;
  logic [N_CH-1:0] idle_p = 2'b01, idle_n = 2'b10;
  logic brk_filt, brk_flag, moe;
  logic [N_CH-1:0] out_p, out_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brk_gate #(.N_CH(N_CH)) i_brk_gate (
    .clk(clk), .rst_n(rst_n), .dts_ce(dts_ce), .brk_pin(brk_pin),
    .flt_sel(flt_sel), .brk_pol(brk_pol), .brk_en(brk_en), .auto_en(auto_en),
    .sw_set(sw_set), .sw_clr(sw_clr), .upd_evt(upd_evt), .flag_clr(flag_clr),
    .en_p(en_p), .en_n(en_n), .pwm_p(pwm_p), .pwm_n(pwm_n),
    .idle_p(idle_p), .idle_n(idle_n), .brk_filt(brk_filt),
    .brk_flag(brk_flag), .moe(moe), .out_p(out_p), .out_n(out_n)
  );

  typedef struct {
    string      req;
    int         sig;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  function automatic logic [7:0] peek(input int sig);
    case (sig)
      0: peek = {7'd0, brk_filt};
      1: peek = {7'd0, brk_flag};
      2: peek = {7'd0, moe};
      3: peek = {6'd0, out_p};
      default: peek = {6'd0, out_n};
    endcase
  endfunction

  task automatic expect_v(input string req, input int sig, input logic [7:0] e);
    q.push_back('{req, sig, e});
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = peek(it.sig);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sig%0d actual %0h expected %0h", it.req, it.sig, act, it.exp);
        end
      end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
    end
  end

  task automatic filter_case(input logic [3:0] s, input int early, input int late);
    brk_pin = 1'b0; flt_sel = 4'd1;
    step(3);
    flt_sel = s; brk_pin = 1'b1;
    step(early);
    expect_v("R3 early", 0, 8'd0);
    step(late - early);
    expect_v("R3 late", 0, 8'd1);
    brk_pin = 1'b0;
    step(late);
    expect_v("R3 release", 0, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    expect_v("reset moe", 2, 8'd0);
    expect_v("reset flag", 1, 8'd0);
    expect_v("reset filt", 0, 8'd0);
    expect_v("R10 idle p", 3, 8'h01);
    expect_v("R10 idle n", 4, 8'h02);
    step(1);

    sw_set = 1'b1; step(1); sw_set = 1'b0;
    expect_v("R8 sw set", 2, 8'd1);
    expect_v("R10 live p", 3, 8'h02);
    expect_v("R10 live n", 4, 8'h03);
    sw_clr = 1'b1; sw_set = 1'b1; step(1); sw_clr = 1'b0; sw_set = 1'b0;
    expect_v("R12 clear wins", 2, 8'd0);
    sw_set = 1'b1; step(1); sw_set = 1'b0;

    brk_en = 1'b0; brk_pin = 1'b1;
    expect_v("R6 disabled moe", 2, 8'd1);
    step(1);
    expect_v("R6 disabled moe held", 2, 8'd1);
    expect_v("R6 disabled flag", 1, 8'd0);
    brk_pin = 1'b0; step(1);

    brk_en = 1'b1; brk_pin = 1'b1;
    expect_v("R7 immediate", 2, 8'd0);
    expect_v("R1 bypass", 0, 8'd1);
    expect_v("R10 forced idle", 3, 8'h01);
    step(1);
    expect_v("R11 flag set", 1, 8'd1);

    sw_set = 1'b1; auto_en = 1'b1; upd_evt = 1'b1; step(1);
    expect_v("R9 break priority", 2, 8'd0);
    sw_set = 1'b0; upd_evt = 1'b0; brk_pin = 1'b0;
    expect_v("R7 stays cleared", 2, 8'd0);
    expect_v("R1 bypass release", 0, 8'd0);
    step(1);
    expect_v("R11 sticky", 1, 8'd1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    expect_v("R11 cleared", 1, 8'd0);

    auto_en = 1'b0; upd_evt = 1'b1; step(1); upd_evt = 1'b0;
    expect_v("R8 no auto", 2, 8'd0);
    auto_en = 1'b1; upd_evt = 1'b1; step(1); upd_evt = 1'b0;
    expect_v("R8 auto set", 2, 8'd1);

    brk_pin = 1'b1; brk_pol = 1'b0;
    expect_v("R5 high inactive", 2, 8'd1);
    step(1);
    brk_pin = 1'b0;
    expect_v("R5 low active", 2, 8'd0);
    step(1);
    brk_pin = 1'b1; flag_clr = 1'b1; sw_set = 1'b1; step(1);
    flag_clr = 1'b0; sw_set = 1'b0;
    expect_v("R5 recover", 2, 8'd1);
    brk_pol = 1'b1; brk_pin = 1'b0; brk_en = 1'b0;

    flt_sel = 4'd1; step(3);
    expect_v("R2 idle", 0, 8'd0);
    brk_pin = 1'b1; step(1);
    expect_v("R2 n2 early", 0, 8'd0);
    step(1);
    expect_v("R2 n2 set", 0, 8'd1);
    brk_pin = 1'b0; step(2);
    expect_v("R2 n2 release", 0, 8'd0);

    brk_pin = 1'b1; step(1); brk_pin = 1'b0; step(1);
    brk_pin = 1'b1; step(1); brk_pin = 1'b0;
    expect_v("R4 glitch", 0, 8'd0);
    step(3);
    expect_v("R4 glitch later", 0, 8'd0);

    flt_sel = 4'd3; brk_pin = 1'b1; step(7);
    expect_v("R2 n8 early", 0, 8'd0);
    step(1);
    expect_v("R2 n8 set", 0, 8'd1);
    brk_pin = 1'b0; step(8);
    expect_v("R2 n8 release", 0, 8'd0);

    filter_case(4'd4, 10, 12);
    filter_case(4'd10, 64, 80);
    filter_case(4'd15, 224, 256);

    step(2);
    done = 1;
    finish_run();
  end
endmodule